// File: doc/BRIEF.md
# Interrupt distributor state register bank

This block holds the per-interrupt state of an interrupt distributor. Each interrupt has six fields: an enable bit, a pending latch, an active bit, an 8-bit priority, a trigger type (level or edge) and a stored line level. Software reaches this state through a simple request port. Each request carries a valid flag, a write flag, a 9-bit word address and 32 bits of write data. A read returns its data one cycle after the request.

The enable, pending and active fields each have a pair of windows. Writing ones in the set window raises the selected bits, and writing ones in the clear window lowers them. Either window of a pair reads back the current state.

Three further windows cover the rest of the state:
- The priority window holds one byte per interrupt. It keeps only the implemented upper bits.
- The configuration window holds two bits per interrupt. The private interrupts cannot change their trigger type.
- The line-level window lets a save/restore agent capture and reload the input line levels.

A legacy-mode input makes the pending windows ignore the software-generated interrupts.

Interrupt numbering: numbers 0 to 15 are software-generated, and numbers 0 to 31 are private. Shared interrupts follow from 32, and the parameter `NUM_SPI` sets how many are implemented.

Top module: `irqbank_top`

## Requirements
- R1: A read request (reqValid=1, reqWrite=0) raises rspValid for exactly the next cycle, with rspRdata holding the addressed word as it stood at the request. Writes and idle cycles leave rspValid low.
- R2: reqAddr[8:5] selects the window and reqAddr[4:0] selects the word. In the set windows (0 enable, 2 pending, 4 active), bit b of word w stands for interrupt 32w+b. A 1 in the write data sets that interrupt's bit, and a 0 leaves it unchanged.
- R3: In the clear windows (1 enable, 3 pending, 5 active), which use the same bit layout, a 1 in the write data clears the bit and a 0 leaves it unchanged.
- R4: A read of either window of a set/clear pair returns the current state bits of that field.
- R5: While legacyMode=1, writes to windows 2 and 3 leave the pending bits of interrupts 0 to 15 unchanged, while still acting on the other interrupts. While legacyMode=0, those bits behave like any other.
- R6: In the priority window (6), byte k of word w is the priority of interrupt 4w+k. A write stores the byte with its lowest 8-PRI_BITS bits forced to zero.
- R7: In the configuration window (7), bits 2j+1:2j of word w belong to interrupt 16w+j. Written bit 2j+1 selects edge (1) or level (0), and written bit 2j is ignored. A read returns 2'b10 for edge and 2'b00 for level.
- R8: Configuration writes to interrupts 0 to 31 have no effect, so these interrupts always read as level.
- R9: In the line-level window (8), bit b of word w stands for interrupt 32w+b. It reads 1 only when that interrupt is allocated, is not software-generated, is level-configured and has its stored line high.
- R10: A write to window 8 stores bit b as the line level of every allocated interrupt numbered 16 or above, whatever its trigger type. Interrupts 0 to 15 are skipped.
- R11: After reset every interrupt is disabled, not pending, inactive, at priority 0, level-triggered and with its line low.
- R12: Bits for interrupts at or above 32+NUM_SPI, and all of windows 9 to 15, read as zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| legacyMode | input | 1 | Makes pending writes skip software-generated interrupts |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 9 | Window in [8:5], word in [4:0] |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after a read |
| rspRdata | output | 32 | Read data |

## Verification
Enable words get mixed patterns of ones and zeros through both windows of a pair. This shows that zero bits leave the state alone and that both windows read the same state.

All-ones pending writes go to word 0 with legacy mode on and then off. The result separates the software-generated bits from the per-CPU bits.

Priority writes use all-ones data and then a mixed byte pattern. These show the narrowing mask and the byte lanes.

Configuration writes use all-ones data and then alternating 01 pairs. These show that private interrupts are protected and that the low bit of each pair is ignored. The line-level window is then read while the same interrupts switch between edge and level. Because the stored line survives the switch, this shows that stored level and visible level are kept apart.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  localparam int IDX_W    = 5;
  localparam int WIN_W    = 4;
  localparam int ADDR_W   = IDX_W + WIN_W;
  localparam int DATA_W   = 32;
  localparam int NUM_SGI  = 16;
  localparam int NUM_PRIV = 32;

  typedef enum logic [WIN_W-1:0] {
    WIN_SET_EN   = 4'd0,
    WIN_CLR_EN   = 4'd1,
    WIN_SET_PEND = 4'd2,
    WIN_CLR_PEND = 4'd3,
    WIN_SET_ACT  = 4'd4,
    WIN_CLR_ACT  = 4'd5,
    WIN_PRIO     = 4'd6,
    WIN_CFG      = 4'd7,
    WIN_LINE     = 4'd8
  } win_e;

  // Strobes from the decoder to the state datapath
  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic             setPend;
    logic             clrPend;
    logic             setAct;
    logic             clrAct;
    logic             wrPrio;
    logic             wrCfg;
    logic             wrLine;
    logic             rdStrobe;
    logic [WIN_W-1:0] win;
    logic [IDX_W-1:0] idx;
  } bankStrobe_t;

endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output bankStrobe_t       strb,
  output logic              rspValid
);

  logic wrReq;
  assign wrReq = reqValid && reqWrite;

  always_comb begin
    strb          = '0;
    strb.win      = reqAddr[ADDR_W-1:IDX_W];
    strb.idx      = reqAddr[IDX_W-1:0];
    strb.rdStrobe = reqValid && !reqWrite;
    case (reqAddr[ADDR_W-1:IDX_W])
      WIN_SET_EN:   strb.setEn   = wrReq;
      WIN_CLR_EN:   strb.clrEn   = wrReq;
      WIN_SET_PEND: strb.setPend = wrReq;
      WIN_CLR_PEND: strb.clrPend = wrReq;
      WIN_SET_ACT:  strb.setAct  = wrReq;
      WIN_CLR_ACT:  strb.clrAct  = wrReq;
      WIN_PRIO:     strb.wrPrio  = wrReq;
      WIN_CFG:      strb.wrCfg   = wrReq;
      WIN_LINE:     strb.wrLine  = wrReq;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strb.rdStrobe;
  end

endmodule

// File: rtl/irqbank_data.sv
module irqbank_data
  import irqbank_pkg::*;
#(
  parameter int NUM_SPI  = 32,
  parameter int PRI_BITS = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         legacyMode,
  input  bankStrobe_t                  strb,
  input  logic [DATA_W-1:0]            reqWdata,
  output logic [DATA_W-1:0]            rspRdata,
  output logic [NUM_PRIV+NUM_SPI-1:0]  enVec,
  output logic [NUM_PRIV+NUM_SPI-1:0]  pendVec,
  output logic [NUM_PRIV+NUM_SPI-1:0]  actVec,
  output logic [NUM_PRIV+NUM_SPI-1:0]  cfgVec,
  output logic [NUM_PRIV+NUM_SPI-1:0]  lineVec,
  output logic [NUM_PRIV+NUM_SPI-1:0][7:0] prioVec
);

  localparam int NUM_IRQ = NUM_PRIV + NUM_SPI;
  localparam logic [7:0] PRIO_KEEP = 8'hFF << (8 - PRI_BITS);

  // the priority window has 32 words of four bytes
  if (NUM_IRQ > 128) begin : g_size_check
    $error("irqbank_data: at most 96 shared interrupts fit the priority window");
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam logic [IDX_W-1:0] BIT_WORD  = IDX_W'(i / 32);
    localparam int               BIT_POS   = i % 32;
    localparam logic [IDX_W-1:0] PRIO_WORD = IDX_W'(i / 4);
    localparam int               PRIO_LANE = i % 4;
    localparam logic [IDX_W-1:0] CFG_WORD  = IDX_W'(i / 16);
    localparam int               CFG_POS   = 2 * (i % 16) + 1;
    localparam bit               IS_SGI    = (i < NUM_SGI);
    localparam bit               IS_PRIV   = (i < NUM_PRIV);

    logic bitHit, prioHit, cfgHit, dBit, pendLock;
    logic en, pend, act, cfg, line;
    logic [7:0] prio;

    assign bitHit   = (strb.idx == BIT_WORD);
    assign prioHit  = (strb.idx == PRIO_WORD);
    assign cfgHit   = (strb.idx == CFG_WORD);
    assign dBit     = reqWdata[BIT_POS];
    assign pendLock = IS_SGI && legacyMode;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en   <= 1'b0;
        pend <= 1'b0;
        act  <= 1'b0;
        cfg  <= 1'b0;
        line <= 1'b0;
        prio <= '0;
      end else begin
        if (bitHit && dBit && strb.setEn) en <= 1'b1;
        else if (bitHit && dBit && strb.clrEn) en <= 1'b0;

        if (bitHit && dBit && !pendLock && strb.setPend) pend <= 1'b1;
        else if (bitHit && dBit && !pendLock && strb.clrPend) pend <= 1'b0;

        if (bitHit && dBit && strb.setAct) act <= 1'b1;
        else if (bitHit && dBit && strb.clrAct) act <= 1'b0;

        if (prioHit && strb.wrPrio)
          prio <= reqWdata[PRIO_LANE*8 +: 8] & PRIO_KEEP;

        if (!IS_PRIV && cfgHit && strb.wrCfg) cfg <= reqWdata[CFG_POS];

        if (!IS_SGI && bitHit && strb.wrLine) line <= dBit;
      end
    end

    assign enVec[i]   = en;
    assign pendVec[i] = pend;
    assign actVec[i]  = act;
    assign cfgVec[i]  = cfg;
    assign lineVec[i] = line;
    assign prioVec[i] = prio;
  end

  logic [DATA_W-1:0] rdWord;

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      case (strb.win)
        WIN_SET_EN, WIN_CLR_EN:
          if (strb.idx == IDX_W'(i / 32)) rdWord[i % 32] = enVec[i];
        WIN_SET_PEND, WIN_CLR_PEND:
          if (strb.idx == IDX_W'(i / 32)) rdWord[i % 32] = pendVec[i];
        WIN_SET_ACT, WIN_CLR_ACT:
          if (strb.idx == IDX_W'(i / 32)) rdWord[i % 32] = actVec[i];
        WIN_PRIO:
          if (strb.idx == IDX_W'(i / 4)) rdWord[(i % 4) * 8 +: 8] = prioVec[i];
        WIN_CFG:
          if (strb.idx == IDX_W'(i / 16)) rdWord[2 * (i % 16) + 1] = cfgVec[i];
        WIN_LINE:
          if (strb.idx == IDX_W'(i / 32)) rdWord[i % 32] = lineVec[i] && !cfgVec[i];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rspRdata <= '0;
    else if (strb.rdStrobe) rspRdata <= rdWord;
  end

endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
#(
  parameter int NUM_SPI  = 32,
  parameter int PRI_BITS = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        legacyMode,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [8:0]  reqAddr,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata
);

  localparam int NUM_IRQ = NUM_PRIV + NUM_SPI;

  bankStrobe_t              strb;
  logic [NUM_IRQ-1:0]       enVec, pendVec, actVec, cfgVec, lineVec;
  logic [NUM_IRQ-1:0][7:0]  prioVec;

  irqbank_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strb     (strb),
    .rspValid (rspValid)
  );

  irqbank_data #(
    .NUM_SPI  (NUM_SPI),
    .PRI_BITS (PRI_BITS)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .legacyMode (legacyMode),
    .strb       (strb),
    .reqWdata   (reqWdata),
    .rspRdata   (rspRdata),
    .enVec      (enVec),
    .pendVec    (pendVec),
    .actVec     (actVec),
    .cfgVec     (cfgVec),
    .lineVec    (lineVec),
    .prioVec    (prioVec)
  );

endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_SGI  = 16,
  parameter int NUM_PRIV = 32,
  parameter int PRI_BITS = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               legacyMode,
  input logic               reqValid,
  input logic               reqWrite,
  input logic [3:0]         reqWin,
  input logic               rspValid,
  input logic [NUM_IRQ-1:0] enVec,
  input logic [NUM_IRQ-1:0] pendVec,
  input logic [NUM_IRQ-1:0] actVec,
  input logic [NUM_IRQ-1:0] cfgVec,
  input logic [NUM_IRQ-1:0] lineVec,
  input logic [NUM_IRQ*8-1:0] prioFlat
);

  localparam logic [7:0] LOW_BITS = ~(8'hFF << (8 - PRI_BITS));
  localparam logic [NUM_IRQ*8-1:0] LOW_ALL = {NUM_IRQ{LOW_BITS}};

  a_r1_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

  a_r5_legacy_sgi_pend: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && legacyMode && (reqWin == 4'd2 || reqWin == 4'd3))
      |=> $stable(pendVec[NUM_SGI-1:0]));

  a_r6_prio_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (prioFlat & LOW_ALL) == '0);

  a_r8_priv_level: assert property (@(posedge clk) disable iff (!rstN)
    cfgVec[NUM_PRIV-1:0] == '0);

  a_r10_sgi_line_low: assert property (@(posedge clk) disable iff (!rstN)
    lineVec[NUM_SGI-1:0] == '0);

  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(enVec) && $stable(pendVec) && $stable(actVec)
                   && $stable(cfgVec) && $stable(lineVec)));

endmodule

bind irqbank_top irqbank_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .NUM_SGI  (irqbank_pkg::NUM_SGI),
  .NUM_PRIV (irqbank_pkg::NUM_PRIV),
  .PRI_BITS (PRI_BITS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .legacyMode (legacyMode),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqWin     (reqAddr[8:5]),
  .rspValid   (rspValid),
  .enVec      (enVec),
  .pendVec    (pendVec),
  .actVec     (actVec),
  .cfgVec     (cfgVec),
  .lineVec    (lineVec),
  .prioFlat   (prioVec)
);

// File: tb/irqbank_top_bench.sv
module irqbank_top_bench;

  localparam int NSPI  = 32;
  localparam int PRI   = 5;
  localparam int NIRQ  = 32 + NSPI;
  localparam logic [7:0] PKEEP = 8'hFF << (8 - PRI);

  localparam int W_SEN = 0, W_CEN = 1, W_SPD = 2, W_CPD = 3, W_SAC = 4,
                 W_CAC = 5, W_PRI = 6, W_CFG = 7, W_LIN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        legacyMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [8:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // behavioural reference state
  bit       mEn[NIRQ];
  bit       mPend[NIRQ];
  bit       mAct[NIRQ];
  bit       mEdge[NIRQ];
  bit       mLine[NIRQ];
  bit [7:0] mPrio[NIRQ];

  always #2 clk = ~clk;

  irqbank_top #(.NUM_SPI(NSPI), .PRI_BITS(PRI)) u_irqbank_top (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  function automatic logic [31:0] modelRead(int win, int idx);
    logic [31:0] r = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (win <= W_CAC || win == W_LIN) begin
        if (i / 32 == idx) begin
          if (win == W_SEN || win == W_CEN) r[i % 32] = mEn[i];
          if (win == W_SPD || win == W_CPD) r[i % 32] = mPend[i];
          if (win == W_SAC || win == W_CAC) r[i % 32] = mAct[i];
          if (win == W_LIN) r[i % 32] = (i >= 16) && !mEdge[i] && mLine[i];
        end
      end else if (win == W_PRI && i / 4 == idx) begin
        r[(i % 4) * 8 +: 8] = mPrio[i];
      end else if (win == W_CFG && i / 16 == idx) begin
        r[(i % 16) * 2 +: 2] = mEdge[i] ? 2'b10 : 2'b00;
      end
    end
    return r;
  endfunction

  function automatic void modelWrite(int win, int idx, logic [31:0] d);
    for (int i = 0; i < NIRQ; i++) begin
      bit hit = (i / 32 == idx);
      bit b   = d[i % 32];
      bit lock = legacyMode && (i < 16);
      case (win)
        W_SEN: if (hit && b) mEn[i] = 1'b1;
        W_CEN: if (hit && b) mEn[i] = 1'b0;
        W_SPD: if (hit && b && !lock) mPend[i] = 1'b1;
        W_CPD: if (hit && b && !lock) mPend[i] = 1'b0;
        W_SAC: if (hit && b) mAct[i] = 1'b1;
        W_CAC: if (hit && b) mAct[i] = 1'b0;
        W_PRI: if (i / 4 == idx) mPrio[i] = d[(i % 4) * 8 +: 8] & PKEEP;
        W_CFG: if (i / 16 == idx && i >= 32) mEdge[i] = d[(i % 16) * 2 + 1];
        W_LIN: if (hit && i >= 16) mLine[i] = b;
        default: ;
      endcase
    end
  endfunction

  task automatic doWrite(int win, int idx, logic [31:0] d, string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1;
    reqAddr = 9'((win << 5) | idx); reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    modelWrite(win, idx, d);
    vectors++;
    if (rspValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 (%s) write raised rspValid: got %b exp 0", tag, rspValid);
    end
  endtask

  task automatic doRead(int win, int idx, string tag);
    logic [31:0] exp;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 9'((win << 5) | idx);
    exp = modelRead(win, idx);
    @(negedge clk);
    reqValid = 1'b0;
    vectors++;
    if (rspValid !== 1'b1 || rspRdata !== exp) begin
      fails++;
      $display("FAIL %s win %0d word %0d: got v=%b %h exp v=1 %h",
               tag, win, idx, rspValid, rspRdata, exp);
    end
  endtask

  task automatic idleCheck(string tag);
    @(negedge clk);
    vectors++;
    if (rspValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 (%s) idle rspValid: got %b exp 0", tag, rspValid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleCheck("after reset");

    // R11: everything zero after reset
    for (int w = 0; w <= W_LIN; w++) doRead(w, 0, "R11 reset");
    for (int k = 0; k < 16; k++) doRead(W_PRI, k, "R11 reset prio");
    for (int k = 0; k < 4; k++) doRead(W_CFG, k, "R11 reset cfg");

    // R2/R3/R4: enable set and clear, read through both windows
    doWrite(W_SEN, 0, 32'hA5A5_0F0F, "R2 set en");
    doWrite(W_SEN, 1, 32'hFFFF_0001, "R2 set en");
    doRead(W_SEN, 0, "R2 R4 en");
    doRead(W_CEN, 0, "R4 en via clear");
    doWrite(W_SEN, 0, 32'h0000_0000, "R2 zero no effect");
    doRead(W_CEN, 0, "R2 zero no effect");
    doWrite(W_CEN, 0, 32'h0F00_0F01, "R3 clr en");
    doWrite(W_CEN, 1, 32'h00F0_0001, "R3 clr en");
    doRead(W_SEN, 0, "R3 en");
    doRead(W_CEN, 1, "R3 R4 en");

    // R5: pending with and without legacy mode
    doWrite(W_SPD, 0, 32'hFFFF_FFFF, "R5 set pend normal");
    doRead(W_SPD, 0, "R5 sgi pend set");
    legacyMode = 1'b1;
    doWrite(W_CPD, 0, 32'hFFFF_FFFF, "R5 clr pend legacy");
    doRead(W_CPD, 0, "R5 legacy keeps sgi pend");
    legacyMode = 1'b0;
    doWrite(W_CPD, 0, 32'h0000_00FF, "R5 clr pend normal");
    doRead(W_SPD, 0, "R5 normal clears sgi");
    legacyMode = 1'b1;
    doWrite(W_SPD, 0, 32'h0001_FFFF, "R5 set pend legacy");
    doRead(W_SPD, 0, "R5 legacy set ignores sgi");
    legacyMode = 1'b0;
    doWrite(W_SPD, 1, 32'h8000_0001, "R2 pend spi");
    doRead(W_CPD, 1, "R4 pend spi");

    // R2/R3: active
    doWrite(W_SAC, 1, 32'h1234_5678, "R2 set act");
    doWrite(W_CAC, 1, 32'h0000_FFFF, "R3 clr act");
    doRead(W_SAC, 1, "R3 R4 act");

    // R6: priority narrowing and lanes
    for (int k = 0; k < 16; k++) doWrite(W_PRI, k, 32'hFFFF_FFFF, "R6 prio ones");
    doRead(W_PRI, 0, "R6 narrow");
    doRead(W_PRI, 15, "R6 narrow");
    doWrite(W_PRI, 9, 32'h1234_5678, "R6 lanes");
    doRead(W_PRI, 9, "R6 lanes");

    // R7/R8: configuration
    for (int k = 0; k < 4; k++) doWrite(W_CFG, k, 32'hFFFF_FFFF, "R7 cfg ones");
    doRead(W_CFG, 0, "R8 sgi cfg fixed");
    doRead(W_CFG, 1, "R8 ppi cfg fixed");
    doRead(W_CFG, 2, "R7 edge");
    doWrite(W_CFG, 3, 32'h5555_5555, "R7 low bit ignored");
    doRead(W_CFG, 3, "R7 level");

    // R9/R10: line level save/restore
    doWrite(W_LIN, 0, 32'hFFFF_FFFF, "R10 line");
    doWrite(W_LIN, 1, 32'hFFFF_FFFF, "R10 line");
    doRead(W_LIN, 0, "R9 sgi zero");
    doRead(W_LIN, 1, "R9 edge masked");
    doWrite(W_CFG, 2, 32'h0000_0000, "R7 back to level");
    doRead(W_LIN, 1, "R10 line kept under edge");
    doWrite(W_LIN, 1, 32'h0F0F_0F0F, "R10 line write");
    doRead(W_LIN, 1, "R10 line pattern");

    // R12: unallocated interrupts and unused windows
    doRead(W_SEN, 2, "R12 unalloc");
    doWrite(W_SEN, 2, 32'hFFFF_FFFF, "R12 unalloc write");
    doRead(W_SEN, 2, "R12 unalloc write");
    doRead(W_SEN, 0, "R12 alloc untouched");
    doRead(W_LIN, 2, "R12 unalloc line");
    doWrite(9, 0, 32'hFFFF_FFFF, "R12 window 9");
    doWrite(15, 1, 32'hFFFF_FFFF, "R12 window 15");
    doRead(9, 0, "R12 window 9");
    doRead(15, 1, "R12 window 15");
    doRead(W_CEN, 1, "R12 state untouched");
    doRead(W_SAC, 0, "R12 state untouched");
    idleCheck("R1 idle");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule